// File: doc/BRIEF.md
# Serial Task-Address Match Unit

This block holds a small unit address that a host loads one bit at a time through an active-low serial input. The unit compares the address with a current-task bus and with the upper nibble of an input address bus. From those compares it drives a task-hit output and two ownership flags. The input flag appears at an active-low pin. The output flag is active high. The unit sits beside a bus controller: the task-hit output tells the controller that the running task belongs to this unit, and the flags record whether the unit currently owns an input or an output transfer.

The register keeps the raw serial pin values. The unit is therefore addressed by the bitwise complement of what was shifted in: shifting four ones makes the unit answer to address zero. Every update happens on the rising edge of one system clock. The shift strobe and the event strobe are one-cycle enables. A synchronous reset is active high.

Each flag is a two-state machine with the states FLAG_OFF and FLAG_ON. There are two transitions. FLAG_OFF goes to FLAG_ON when the flag's set pulse is high. FLAG_ON goes to FLAG_OFF when the flag's clear condition is high and its set pulse is low.
- The input flag's clear condition is an event strobe while the unit is not selected.
- The output flag's clear condition is that same event case, or an explicit reset pulse, or an input-valid strobe.

Top module: `serial_task_match`

## Requirements
- R1: Each cycle with `shift_en` high moves `ser_in_n` into address bit 3 and shifts bits 3..1 down by one place. `ser_out_n` always shows address bit 0. With `shift_en` low the address holds.
- R2: Four shifts with `ser_in_n` low clear the address. `ser_out_n` then reads 0.
- R3: `task_hit` is high exactly when `task_bus` equals the bitwise complement of the address. It is combinational, so it is valid in the same cycle as its inputs.
- R4: The address compare checks `in_addr[7:4]` against the complemented address. `in_addr[3:0]` has no effect. The unit counts as selected only when both the task compare and the address compare hit.
- R5: An `evt_en` cycle while the unit is not selected clears both flags. After the edge, `in_flag_n` is 1 and `out_flag` is 0.
- R6: An `evt_en` cycle while the unit is selected leaves both flags unchanged.
- R7: An `in_flag_set` pulse drives `in_flag_n` to 0 after the edge. It stays 0 until a clear.
- R8: An `out_flag_set` pulse drives `out_flag` to 1. A cycle with `out_flag_clr` high or `in_valid` high drives it back to 0.
- R9: When a flag's set pulse and any of that flag's clear conditions occur in the same cycle, the set pulse wins.
- R10: A cycle with `rst` high clears the address to 0, sets `in_flag_n` to 1 and sets `out_flag` to 0.
- R11: With the address loaded as 1111 and both buses at zero, `task_hit` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| shift_en | input | 1 | One-cycle shift strobe |
| ser_in_n | input | 1 | Serial address data, active low |
| evt_en | input | 1 | One-cycle event strobe |
| task_bus | input | 4 | Current task number |
| in_addr | input | 8 | Input address bus; bits 7:4 are compared |
| in_valid | input | 1 | Input sequence complete strobe; clears the output flag |
| in_flag_set | input | 1 | Set pulse for the input flag |
| out_flag_set | input | 1 | Set pulse for the output flag |
| out_flag_clr | input | 1 | Reset pulse for the output flag |
| ser_out_n | output | 1 | Serial output, address bit 0 |
| task_hit | output | 1 | Task bus matches the complemented address |
| in_flag_n | output | 1 | Input ownership flag, active low |
| out_flag | output | 1 | Output ownership flag, active high |

## Verification
`task_hit` is due in the same cycle as the bus and address values that produce it. `ser_out_n`, `in_flag_n` and `out_flag` change only at the rising edge that follows the strobe. The driver changes inputs on the falling edge and queues the values it expects after the next rising edge. The monitor compares them 2 ns after that rising edge. Because no input moves between that edge and the sample, the combinational hit is compared against the freshly updated address and the bus value already driven.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
    typedef enum logic {
        FLAG_OFF = 1'b0,
        FLAG_ON  = 1'b1
    } flag_state_e;
endpackage

// File: rtl/tmu_shift_reg.sv
module tmu_shift_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         ser_in_n,
    output logic [W-1:0] addr_q,
    output logic         ser_out_n
);
    logic [W-1:0] addr_d;

    always_comb begin
        addr_d = addr_q;
        if (shift_en) begin
            addr_d = {ser_in_n, addr_q[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign ser_out_n = addr_q[0];
endmodule

// File: rtl/tmu_compare.sv
module tmu_compare #(
    parameter int W    = 4,
    parameter int IN_W = 8
) (
    input  logic [W-1:0]    addr_q,
    input  logic [W-1:0]    task_bus,
    input  logic [IN_W-1:0] in_addr,
    output logic            task_hit,
    output logic            addr_hit
);
    localparam int HI = IN_W - 1;

    logic [W-1:0] target;
    logic [W-1:0] upper;

    assign target   = ~addr_q;
    assign upper    = in_addr[HI -: W];
    assign task_hit = (task_bus == target);
    assign addr_hit = (upper == target);
endmodule

// File: rtl/tmu_flag.sv
module tmu_flag
    import tmu_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic active_o
);
    flag_state_e state_q;
    flag_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_OFF: if (set_i) state_d = FLAG_ON;
            FLAG_ON:  if (clr_i && !set_i) state_d = FLAG_OFF;
            default:  state_d = FLAG_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FLAG_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        active_o = (state_q == FLAG_ON);
    end
endmodule

// File: rtl/serial_task_match.sv
module serial_task_match #(
    parameter int ADDR_W = 4,
    parameter int IN_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              ser_in_n,
    input  logic              evt_en,
    input  logic [ADDR_W-1:0] task_bus,
    input  logic [IN_W-1:0]   in_addr,
    input  logic              in_valid,
    input  logic              in_flag_set,
    input  logic              out_flag_set,
    input  logic              out_flag_clr,
    output logic              ser_out_n,
    output logic              task_hit,
    output logic              in_flag_n,
    output logic              out_flag
);
    logic [ADDR_W-1:0] addr_q;
    logic              addr_hit;
    logic              selected;
    logic              evt_drop;
    logic              in_active;
    logic              out_clr;

    tmu_shift_reg #(.W(ADDR_W)) u_sreg (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .ser_in_n  (ser_in_n),
        .addr_q    (addr_q),
        .ser_out_n (ser_out_n)
    );

    tmu_compare #(.W(ADDR_W), .IN_W(IN_W)) u_cmp (
        .addr_q   (addr_q),
        .task_bus (task_bus),
        .in_addr  (in_addr),
        .task_hit (task_hit),
        .addr_hit (addr_hit)
    );

    // The event strobe drops ownership unless both compares hit.
    assign selected = task_hit & addr_hit;
    assign evt_drop = evt_en & ~selected;
    assign out_clr  = evt_drop | out_flag_clr | in_valid;

    tmu_flag u_in_flag (
        .clk      (clk),
        .rst      (rst),
        .set_i    (in_flag_set),
        .clr_i    (evt_drop),
        .active_o (in_active)
    );

    tmu_flag u_out_flag (
        .clk      (clk),
        .rst      (rst),
        .set_i    (out_flag_set),
        .clr_i    (out_clr),
        .active_o (out_flag)
    );

    assign in_flag_n = ~in_active;
endmodule

// File: rtl/serial_task_match_chk.sv
module serial_task_match_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              shift_en,
    input logic              evt_en,
    input logic [ADDR_W-1:0] task_bus,
    input logic              task_hit,
    input logic              in_valid,
    input logic              in_flag_set,
    input logic              out_flag_set,
    input logic              out_flag_clr,
    input logic              ser_out_n,
    input logic              in_flag_n,
    input logic              out_flag
);
    AST_HOLD_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(ser_out_n)); // R1

    AST_HIT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!shift_en && !$isunknown(task_bus)) ##1 $stable(task_bus) |-> $stable(task_hit)); // R3

    AST_EVT_DROP: assert property (@(posedge clk) disable iff (rst)
        (evt_en && !task_hit && !in_flag_set && !out_flag_set) |=> (in_flag_n && !out_flag)); // R5

    AST_IN_SET: assert property (@(posedge clk) disable iff (rst)
        in_flag_set |=> !in_flag_n); // R7

    AST_OUT_CLR: assert property (@(posedge clk) disable iff (rst)
        ((out_flag_clr || in_valid) && !out_flag_set) |=> !out_flag); // R8

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (out_flag_set && (out_flag_clr || in_valid || evt_en)) |=> out_flag); // R9

    AST_IN_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!evt_en && !in_flag_set) |=> $stable(in_flag_n)); // R7
endmodule

bind serial_task_match serial_task_match_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .shift_en     (shift_en),
    .evt_en       (evt_en),
    .task_bus     (task_bus),
    .task_hit     (task_hit),
    .in_valid     (in_valid),
    .in_flag_set  (in_flag_set),
    .out_flag_set (out_flag_set),
    .out_flag_clr (out_flag_clr),
    .ser_out_n    (ser_out_n),
    .in_flag_n    (in_flag_n),
    .out_flag     (out_flag)
);

// File: tb/serial_task_match_bench.sv
`timescale 1ns/1ps
module serial_task_match_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shift_en = 1'b0;
    logic       ser_in_n = 1'b0;
    logic       evt_en = 1'b0;
    logic [3:0] task_bus = 4'h0;
    logic [7:0] in_addr = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_flag_set = 1'b0;
    logic       out_flag_set = 1'b0;
    logic       out_flag_clr = 1'b0;
    logic       ser_out_n;
    logic       task_hit;
    logic       in_flag_n;
    logic       out_flag;

    always #5 clk = ~clk;

    serial_task_match u_serial_task_match (
        .clk (clk), .rst (rst), .shift_en (shift_en), .ser_in_n (ser_in_n),
        .evt_en (evt_en), .task_bus (task_bus), .in_addr (in_addr),
        .in_valid (in_valid), .in_flag_set (in_flag_set),
        .out_flag_set (out_flag_set), .out_flag_clr (out_flag_clr),
        .ser_out_n (ser_out_n), .task_hit (task_hit),
        .in_flag_n (in_flag_n), .out_flag (out_flag)
    );

    typedef struct {
        string tag;
        int    sig;
        logic  exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    failures = 0;
    bit    done = 0;

    logic [3:0] m_addr = 4'h0;
    logic       m_in = 1'b0;
    logic       m_out = 1'b0;

    function automatic logic pick(int s);
        case (s)
            0: return ser_out_n;
            1: return task_hit;
            2: return in_flag_n;
            default: return out_flag;
        endcase
    endfunction

    function automatic string sname(int s);
        case (s)
            0: return "ser_out_n";
            1: return "task_hit";
            2: return "in_flag_n";
            default: return "out_flag";
        endcase
    endfunction

    // Monitor: compare queued expectations shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (q.size() > 0) begin
                item_t it;
                logic  act;
                it  = q.pop_front();
                act = pick(it.sig);
                checks++;
                if (act !== it.exp) begin
                    failures++;
                    $display("FAIL %s %s actual=%b expected=%b", it.tag, sname(it.sig), act, it.exp);
                end
            end
        end
    end

    // Driver: drive on the falling edge, update the model, queue expectations.
    task automatic step(input string tag, input logic r, input logic sh, input logic sd,
                        input logic ev, input logic [3:0] tb, input logic [7:0] ia,
                        input logic iv, input logic iset, input logic oset, input logic oclr);
        logic sel;
        @(negedge clk);
        rst = r; shift_en = sh; ser_in_n = sd; evt_en = ev; task_bus = tb;
        in_addr = ia; in_valid = iv; in_flag_set = iset; out_flag_set = oset;
        out_flag_clr = oclr;
        sel = (tb == ~m_addr) && (ia[7:4] == ~m_addr);
        if (r) begin
            m_addr = 4'h0; m_in = 1'b0; m_out = 1'b0;
        end else begin
            if (sh) m_addr = {sd, m_addr[3:1]};
            if (iset) m_in = 1'b1;
            else if (ev && !sel) m_in = 1'b0;
            if (oset) m_out = 1'b1;
            else if (oclr || iv || (ev && !sel)) m_out = 1'b0;
        end
        q.push_back('{tag, 0, m_addr[0]});
        q.push_back('{tag, 1, (tb == ~m_addr)});
        q.push_back('{tag, 2, ~m_in});
        q.push_back('{tag, 3, m_out});
    endtask

    task automatic idle(input string tag, input logic [3:0] tb, input logic [7:0] ia);
        step(tag, 0, 0, 0, 0, tb, ia, 0, 0, 0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step("R10", 1, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0, 0);
        // R2: four zeros clear
        for (int i = 0; i < 4; i++) step("R2", 0, 1, 0, 0, 4'h3, 8'h00, 0, 0, 0, 0);
        // R1 / R3: walk ones in, sweep task values each time
        for (int i = 0; i < 4; i++) begin
            step("R1", 0, 1, 1, 0, 4'h0, 8'h00, 0, 0, 0, 0);
            for (int j = 0; j < 16; j++) idle("R3", 4'(j), 8'h00);
        end
        // R1: walk zeros in
        for (int i = 0; i < 4; i++) begin
            step("R1", 0, 1, 0, 0, 4'h0, 8'h00, 0, 0, 0, 0);
            for (int j = 0; j < 16; j++) idle("R3", 4'(j), 8'h00);
        end
        // address now 0000 -> unit answers to 4'hF
        // R4 / R6: selected event keeps flags; low nibble ignored
        step("R7", 0, 0, 0, 0, 4'hF, 8'hF0, 0, 1, 1, 0);
        for (int k = 0; k < 16; k++)
            step("R6", 0, 0, 0, 1, 4'hF, {4'hF, 4'(k)}, 0, 0, 0, 0);
        // R4: task hits but upper nibble misses -> event clears
        step("R4", 0, 0, 0, 1, 4'hF, 8'hEF, 0, 0, 0, 0);
        // R5: task miss clears
        step("R7", 0, 0, 0, 0, 4'h1, 8'hF0, 0, 1, 1, 0);
        idle("R7", 4'h1, 8'hF0);
        step("R5", 0, 0, 0, 1, 4'h1, 8'hF0, 0, 0, 0, 0);
        // R8: explicit clear and input-valid clear
        step("R8", 0, 0, 0, 0, 4'h1, 8'h00, 0, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 4'h1, 8'h00, 0, 0, 0, 1);
        step("R8", 0, 0, 0, 0, 4'h1, 8'h00, 0, 0, 1, 0);
        step("R8", 0, 0, 0, 0, 4'h1, 8'h00, 1, 0, 0, 0);
        // R9: set beats clears
        step("R9", 0, 0, 0, 1, 4'h1, 8'h00, 1, 1, 1, 1);
        idle("R9", 4'h1, 8'h00);
        step("R9", 0, 0, 0, 1, 4'h1, 8'h00, 0, 0, 0, 0);
        // R11: load 1111, buses zero
        for (int i = 0; i < 4; i++) step("R11", 0, 1, 1, 0, 4'h5, 8'h55, 0, 0, 0, 0);
        idle("R11", 4'h0, 8'h00);
        // R10: reset from a loaded state with flags set
        step("R10", 0, 0, 0, 0, 4'h0, 8'h00, 0, 1, 1, 0);
        step("R10", 1, 0, 0, 0, 4'h0, 8'h00, 0, 0, 0, 0);
        idle("R10", 4'h0, 8'h00);
        @(posedge clk);
        #5;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule